// File: doc/BRIEF.md
# Chained-Descriptor Copy Engine

This block is one channel of a memory-to-memory copy engine. Its work comes from a chain of descriptors held in memory. Each descriptor is four 32-bit words on a 32-byte boundary. The engine reads a descriptor's four words and then moves the byte count the descriptor asks for, from a source address to a target address. Each address either steps by one per byte or stays fixed. The engine then goes on to the descriptor named by the next-pointer word. It halts once it has finished a descriptor whose next-pointer word carries the stop mark.

Software writes the address of the first descriptor into the channel's pointer register and then writes the start bit. A status register shows whether the channel is running. It also holds a sticky end flag, which a descriptor sets when it asks for one and which drives the interrupt output. Data moves in groups: the engine reads up to one burst of bytes into a local buffer, then writes that group out before it reads the next one.

Top module: `ldma_engine`

## Requirements
- R1: After reset the status register reads 0, the pointer register reads 0, `irq_o` is 0 and `mem_req_o` is 0.
- R2: Each descriptor is fetched as four word reads at pointer+0, +4, +8 and +12, in that order: next word, source, target, command. All four complete before any byte access. A request, with its address and direction, is held until `mem_ack_i` is high at a clock edge.
- R3: With both increment bits set, the `len` bytes at the source are copied in order to the target. No byte beyond the target range is written. Command word: len = bits 12:0, burst code = bits 17:16, end-flag request = bit 21, target increment = bit 30, source increment = bit 31.
- R4: A clear source-increment bit makes every byte read come from the source address. A clear target-increment bit makes every byte write go to the target address, so the last byte written stays there.
- R5: Reads are grouped ahead of writes. The longest run of back-to-back byte reads equals min(burst, len), where burst code 0 = 8 bytes, 1 = 16 bytes, and 2 or 3 = 32 bytes.
- R6: When bit 0 of the next word is 0, the engine fetches the next descriptor at that word with bits 4:0 cleared. When bit 0 is 1, the engine halts after the current descriptor and ignores the address bits.
- R7: A descriptor with len 0 is fetched but makes no byte access, and the chain goes on.
- R8: Completing a descriptor whose command bit 21 is set raises the end flag (status bit 1) and `irq_o`. A descriptor without that bit leaves both unchanged. The flag stays set until a write to status with bit 1 = 1. A status write with bit 1 = 0 has no effect on it.
- R9: Writing 1 to control bit 0 at offset 0x00 while idle starts the chain. Status (offset 0x04) bit 0 reads 1 while running and 0 once halted. A start write while running is ignored.
- R10: The pointer register sits at 0x40 + (channel index << 4), which is 0x60 by default, and reads back with bits 4:0 cleared. Writes to it while running are ignored. Unmapped offsets read 0.
- R11: A single descriptor moves up to 8191 bytes, the largest value of the 13-bit len field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | REG_AW | Register byte offset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i`, combinational |
| mem_req_o | output | 1 | Bus request, held until acknowledged |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_word_o | output | 1 | 1 = 32-bit descriptor read, 0 = byte access on bits 7:0 |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 32 | Write data, byte in bits 7:0 |
| mem_rdata_i | input | 32 | Read data, valid with `mem_ack_i` |
| mem_ack_i | input | 1 | Completes the current request at the clock edge |
| irq_o | output | 1 | Sticky end-of-chain interrupt |

## Verification
A wrong word counter or next-pointer register shows up at the bus within a single descriptor. Fetch addresses leave the expected +0/+4/+8/+12 pattern, or the engine fetches from a place no chain points to. A wrong remaining-byte count or buffer index changes how many bytes move, or their order, which can be seen in target memory and in the sentinel byte past it once the descriptor completes. Grouping faults show up in the length of read runs within the first burst. Faults in the flag and pointer registers appear on the next register read or on `irq_o` one cycle after the last descriptor completes.

// File: rtl/ldma_pkg.sv
`timescale 1ns/1ps
package ldma_pkg;
  localparam int LEN_W     = 13;
  localparam int BURST_LSB = 16;
  localparam int IRQ_BIT   = 21;
  localparam int DINC_BIT  = 30;
  localparam int SINC_BIT  = 31;
  localparam logic [31:0] ALIGN_MASK = 32'hFFFF_FFE0;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_SETUP, S_RD, S_WR, S_END
  } seq_state_e;

  function automatic int unsigned burst_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 16;
      default: return 32;
    endcase
  endfunction
endpackage

// File: rtl/ldma_buf.sv
`timescale 1ns/1ps
module ldma_buf #(
  parameter int DEPTH = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [7:0]    wr_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [7:0]    rd_data_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/ldma_regs.sv
`timescale 1ns/1ps
module ldma_regs #(
  parameter int unsigned       REG_AW   = 8,
  parameter logic [REG_AW-1:0] CTRL_OFF = '0,
  parameter logic [REG_AW-1:0] STAT_OFF = REG_AW'(4),
  parameter logic [REG_AW-1:0] PTR_OFF  = REG_AW'(8'h60)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              busy_i,
  input  logic              end_evt_i,
  output logic              start_o,
  output logic [31:0]       ptr_o,
  output logic              irq_o
);
  import ldma_pkg::*;

  logic [31:0] ptr_q;
  logic        flag_q;
  logic        hit_ctl, hit_sts, hit_ptr, clr_flag;

  assign hit_ctl  = reg_addr_i == CTRL_OFF;
  assign hit_sts  = reg_addr_i == STAT_OFF;
  assign hit_ptr  = reg_addr_i == PTR_OFF;
  assign clr_flag = reg_we_i && hit_sts && reg_wdata_i[1];
  assign start_o  = reg_we_i && hit_ctl && reg_wdata_i[0] && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (reg_we_i && hit_ptr && !busy_i) ptr_q <= reg_wdata_i & ALIGN_MASK;
      if (end_evt_i)     flag_q <= 1'b1;
      else if (clr_flag) flag_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (hit_ctl)      reg_rdata_o[0]   = busy_i;
    else if (hit_sts) reg_rdata_o[1:0] = {flag_q, busy_i};
    else if (hit_ptr) reg_rdata_o      = ptr_q;
  end

  assign ptr_o = ptr_q;
  assign irq_o = flag_q;

  a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !clr_flag |=> flag_q);
  a_r10_ptr_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(ptr_q));
endmodule

// File: rtl/ldma_seq.sv
`timescale 1ns/1ps
module ldma_seq #(
  parameter int MAX_BURST = 32,
  localparam int CNT_W = $clog2(MAX_BURST + 1),
  localparam int IW    = $clog2(MAX_BURST)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [31:0]   ptr_i,
  output logic          busy_o,
  output logic          end_evt_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic          mem_word_o,
  output logic [31:0]   mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  input  logic          mem_ack_i,
  output logic          buf_we_o,
  output logic [IW-1:0] buf_widx_o,
  output logic [7:0]    buf_wdata_o,
  output logic [IW-1:0] buf_ridx_o,
  input  logic [7:0]    buf_rdata_i
);
  import ldma_pkg::*;

  seq_state_e       st_q;
  logic [31:0]      dptr_q, nxt_q, src_q, dst_q;
  logic [1:0]       widx_q, burst_q;
  logic [LEN_W-1:0] len_q, rem_q;
  logic             irq_q, sinc_q, dinc_q;
  logic [CNT_W-1:0] cnt_q, wpos_q, burst_len;
  logic             xfer;

  assign burst_len = CNT_W'(burst_bytes(burst_q));
  assign xfer      = mem_req_o && mem_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      dptr_q <= '0; nxt_q <= '0; src_q <= '0; dst_q <= '0;
      widx_q <= '0; burst_q <= '0; len_q <= '0; rem_q <= '0;
      irq_q  <= 1'b0; sinc_q <= 1'b0; dinc_q <= 1'b0;
      cnt_q  <= '0; wpos_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start_i) begin
          dptr_q <= ptr_i;
          widx_q <= '0;
          st_q   <= S_FETCH;
        end
        S_FETCH: if (xfer) begin
          case (widx_q)
            2'd0: nxt_q <= mem_rdata_i;
            2'd1: src_q <= mem_rdata_i;
            2'd2: dst_q <= mem_rdata_i;
            default: begin
              len_q   <= mem_rdata_i[LEN_W-1:0];
              burst_q <= mem_rdata_i[BURST_LSB +: 2];
              irq_q   <= mem_rdata_i[IRQ_BIT];
              dinc_q  <= mem_rdata_i[DINC_BIT];
              sinc_q  <= mem_rdata_i[SINC_BIT];
              st_q    <= S_SETUP;
            end
          endcase
          widx_q <= widx_q + 2'd1;
        end
        S_SETUP: begin
          rem_q <= len_q;
          cnt_q <= '0;
          st_q  <= (len_q == '0) ? S_END : S_RD;
        end
        S_RD: if (xfer) begin
          cnt_q <= cnt_q + CNT_W'(1);
          rem_q <= rem_q - LEN_W'(1);
          src_q <= src_q + {31'b0, sinc_q};
          if ((cnt_q + CNT_W'(1) == burst_len) || (rem_q == LEN_W'(1))) begin
            wpos_q <= '0;
            st_q   <= S_WR;
          end
        end
        S_WR: if (xfer) begin
          dst_q  <= dst_q + {31'b0, dinc_q};
          wpos_q <= wpos_q + CNT_W'(1);
          if (wpos_q + CNT_W'(1) == cnt_q) begin
            cnt_q <= '0;
            st_q  <= (rem_q == '0) ? S_END : S_RD;
          end
        end
        S_END: begin
          if (nxt_q[0]) st_q <= S_IDLE;
          else begin
            dptr_q <= nxt_q & ALIGN_MASK;
            widx_q <= '0;
            st_q   <= S_FETCH;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_word_o  = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    case (st_q)
      S_FETCH: begin
        mem_req_o  = 1'b1;
        mem_word_o = 1'b1;
        mem_addr_o = dptr_q + 32'({widx_q, 2'b00});
      end
      S_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = src_q;
      end
      S_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = dst_q;
        mem_wdata_o = {24'b0, buf_rdata_i};
      end
      default: ;
    endcase
  end

  assign busy_o      = st_q != S_IDLE;
  assign end_evt_o   = (st_q == S_END) && irq_q;
  assign buf_we_o    = (st_q == S_RD) && xfer;
  assign buf_widx_o  = cnt_q[IW-1:0];
  assign buf_wdata_o = mem_rdata_i[7:0];
  assign buf_ridx_o  = wpos_q[IW-1:0];

  a_r2_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  a_r2_fetch_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_word_o |-> !mem_we_o && mem_addr_o[4] == 1'b0 && mem_addr_o[1:0] == 2'b00);
  a_r5_burst_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= burst_len);
  a_r7_no_empty_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == S_RD |-> rem_q != '0);
  a_r9_start_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
endmodule

// File: rtl/ldma_engine.sv
`timescale 1ns/1ps
module ldma_engine #(
  parameter int unsigned REG_AW    = 8,
  parameter int unsigned CHAN_IDX  = 2,
  parameter int unsigned DESC_BASE = 32'h40,
  parameter int unsigned CTRL_ADDR = 32'h00,
  parameter int unsigned STAT_ADDR = 32'h04,
  parameter int          MAX_BURST = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_word_o,
  output logic [31:0]       mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  input  logic              mem_ack_i,
  output logic              irq_o
);
  localparam logic [REG_AW-1:0] PTR_OFF = REG_AW'(DESC_BASE + (CHAN_IDX << 4));
  localparam logic [REG_AW-1:0] CTL_OFF = REG_AW'(CTRL_ADDR);
  localparam logic [REG_AW-1:0] STS_OFF = REG_AW'(STAT_ADDR);
  localparam int IW = $clog2(MAX_BURST);

  logic          busy, end_evt, start;
  logic [31:0]   ptr;
  logic          buf_we;
  logic [IW-1:0] buf_widx, buf_ridx;
  logic [7:0]    buf_wdata, buf_rdata;

  ldma_regs #(
    .REG_AW(REG_AW), .CTRL_OFF(CTL_OFF), .STAT_OFF(STS_OFF), .PTR_OFF(PTR_OFF)
  ) u_regs (
    .clk_i, .rst_ni, .reg_addr_i, .reg_we_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy), .end_evt_i(end_evt), .start_o(start), .ptr_o(ptr), .irq_o
  );

  ldma_seq #(.MAX_BURST(MAX_BURST)) u_seq (
    .clk_i, .rst_ni, .start_i(start), .ptr_i(ptr), .busy_o(busy), .end_evt_o(end_evt),
    .mem_req_o, .mem_we_o, .mem_word_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i, .mem_ack_i,
    .buf_we_o(buf_we), .buf_widx_o(buf_widx), .buf_wdata_o(buf_wdata),
    .buf_ridx_o(buf_ridx), .buf_rdata_i(buf_rdata)
  );

  ldma_buf #(.DEPTH(MAX_BURST)) u_buf (
    .clk_i, .wr_en_i(buf_we), .wr_idx_i(buf_widx), .wr_data_i(buf_wdata),
    .rd_idx_i(buf_ridx), .rd_data_o(buf_rdata)
  );
endmodule

// File: tb/tb_ldma_engine.sv
`timescale 1ns/1ps
module tb_ldma_engine;
  localparam logic [7:0] CTL = 8'h00, STS = 8'h04, PTR = 8'h60;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_we, mem_word, mem_ack = 1'b0, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

  ldma_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_we_i(reg_we),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_word_o(mem_word), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack), .irq_o(irq)
  );

  logic [7:0]  mem [0:32767];
  logic [15:0] lfsr = 16'hACE1;
  logic [14:0] ma;
  int checks = 0, errors = 0;
  bit done = 0;
  int rd_n, wr_n, run, max_run, fetch_n, fetch_first;
  logic [31:0] fetch_log [0:15];

  // bus model with pseudo-random wait states
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rst_n && mem_req && (lfsr[0] | lfsr[3])) begin
      ma = mem_addr[14:0];
      mem_ack = 1'b1;
      if (mem_word) begin
        mem_rdata = {mem[ma + 15'd3], mem[ma + 15'd2], mem[ma + 15'd1], mem[ma]};
        if (fetch_n < 16) fetch_log[fetch_n] = mem_addr;
        fetch_n++;
      end else if (!mem_we) begin
        mem_rdata = {24'h0, mem[ma]};
        if (rd_n == 0 && wr_n == 0) fetch_first = fetch_n;
        rd_n++;
        run++;
      end else begin
        mem[ma] = mem_wdata[7:0];
        wr_n++;
        if (run > max_run) max_run = run;
        run = 0;
      end
    end else begin
      mem_ack = 1'b0;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b0;
    #1 d = reg_rdata;
  endtask

  task automatic put_desc(input int a, input logic [31:0] nxt, src, dst, cmd);
    logic [31:0] w [4];
    w = '{nxt, src, dst, cmd};
    for (int k = 0; k < 4; k++)
      for (int b = 0; b < 4; b++) mem[a + 4*k + b] = w[k][8*b +: 8];
  endtask

  function automatic logic [31:0] mk_cmd(input int len, input int bc, input bit si, ti, ie);
    return {si, ti, 8'b0, ie, 3'b0, 2'(bc), 3'b0, 13'(len)};
  endfunction

  task automatic clr_stats();
    rd_n = 0; wr_n = 0; run = 0; max_run = 0; fetch_n = 0; fetch_first = -1;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    do reg_rd(STS, s); while (s[0]);
  endtask

  task automatic run_chain(input logic [31:0] p);
    clr_stats();
    reg_wr(PTR, p);
    reg_wr(CTL, 32'h1);
    wait_idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int lens [8] = '{1, 7, 8, 9, 31, 32, 33, 100};
    int mism, len, bb;
    for (int i = 0; i < 32768; i++) mem[i] = 8'h00;
    clr_stats();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 req", {31'b0, mem_req}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    rst_n = 1'b1;
    reg_rd(STS, d); chk("R1 status", d, 0);
    reg_rd(PTR, d); chk("R1 ptr", d, 0);

    // R10 pointer alignment and decode
    reg_wr(PTR, 32'h0000_2A3F);
    reg_rd(PTR, d);   chk("R10 ptr readback", d, 32'h0000_2A20);
    reg_rd(8'h50, d); chk("R10 other slot", d, 0);

    // R3 R5 R2 R8 sweep over burst codes and lengths
    for (int bc = 0; bc < 4; bc++) begin
      for (int li = 0; li < 8; li++) begin
        len = lens[li];
        bb = (bc == 0) ? 8 : (bc == 1) ? 16 : 32;
        for (int i = 0; i < len; i++) mem[16'h1000 + i] = 8'((i*7 + bc*13 + li) & 255);
        for (int i = 0; i <= len; i++) mem[16'h4000 + i] = 8'hEE;
        put_desc(32'h100, 32'h1, 32'h1000, 32'h4000, mk_cmd(len, bc, 1, 1, 1));
        run_chain(32'h100);
        mism = 0;
        for (int i = 0; i < len; i++) if (mem[16'h4000 + i] !== mem[16'h1000 + i]) mism++;
        chk("R3 data mismatches", mism, 0);
        chk("R3 sentinel", {24'b0, mem[16'h4000 + len]}, 32'hEE);
        chk("R3 read count", rd_n, len);
        chk("R5 longest read run", max_run, (len < bb) ? len : bb);
        chk("R2 fetch count", fetch_n, 4);
        for (int k = 0; k < 4; k++) chk("R2 fetch addr", fetch_log[k], 32'h100 + 4*k);
        chk("R2 fetch before data", fetch_first, 4);
        #1 chk("R8 irq set", {31'b0, irq}, 1);
        reg_wr(STS, 32'h2);
        #1 chk("R8 irq cleared", {31'b0, irq}, 0);
      end
    end

    // R6 R7 R4 chain: A -> B(len 0) -> C(stop, fixed source)
    for (int i = 0; i < 20; i++) mem[16'h1000 + i] = 8'(8'h30 + i);
    mem[16'h1200] = 8'h5A; mem[16'h1201] = 8'hA5;
    for (int i = 0; i < 16; i++) begin
      mem[16'h4000 + i] = 8'hEE; mem[16'h4100 + i] = 8'hEE; mem[16'h4200 + i] = 8'hEE;
    end
    for (int i = 16; i < 24; i++) mem[16'h4000 + i] = 8'hEE;
    put_desc(32'h200, 32'h240 | 32'h1E, 32'h1000, 32'h4000, mk_cmd(20, 0, 1, 1, 0));
    put_desc(32'h240, 32'h280, 32'h1100, 32'h4100, mk_cmd(0, 0, 1, 1, 0));
    put_desc(32'h280, 32'h2A1, 32'h1200, 32'h4200, mk_cmd(12, 1, 0, 1, 1));
    run_chain(32'h200);
    chk("R6 fetch count", fetch_n, 12);
    for (int k = 0; k < 12; k++)
      chk("R6 fetch addr", fetch_log[k], 32'h200 + 32'h40*(k/4) + 4*(k%4));
    mism = 0;
    for (int i = 0; i < 20; i++) if (mem[16'h4000 + i] !== 8'(8'h30 + i)) mism++;
    chk("R6 first descriptor data", mism, 0);
    chk("R3 chain sentinel", {24'b0, mem[16'h4014]}, 32'hEE);
    chk("R7 zero-length target untouched", {24'b0, mem[16'h4100]}, 32'hEE);
    chk("R7 byte reads in chain", rd_n, 32);
    mism = 0;
    for (int i = 0; i < 12; i++) if (mem[16'h4200 + i] !== 8'h5A) mism++;
    chk("R4 fixed source", mism, 0);
    chk("R4 fixed source sentinel", {24'b0, mem[16'h420C]}, 32'hEE);
    #1 chk("R8 irq after chain", {31'b0, irq}, 1);
    reg_wr(STS, 32'h2);

    // R4 fixed target
    for (int i = 0; i < 10; i++) mem[16'h1000 + i] = 8'(8'h70 + i);
    mem[16'h4300] = 8'hEE; mem[16'h4301] = 8'hEE;
    put_desc(32'h300, 32'h1, 32'h1000, 32'h4300, mk_cmd(10, 2, 1, 0, 1));
    run_chain(32'h300);
    chk("R4 fixed target last byte", {24'b0, mem[16'h4300]}, 32'h79);
    chk("R4 fixed target neighbour", {24'b0, mem[16'h4301]}, 32'hEE);
    chk("R4 write count", wr_n, 10);
    // R8 writing 0 leaves flag, writing bit1 clears
    reg_wr(STS, 32'h0);
    #1 chk("R8 zero write keeps irq", {31'b0, irq}, 1);
    reg_rd(STS, d); chk("R8 status flag", d, 32'h2);
    reg_wr(STS, 32'h2);
    reg_rd(STS, d); chk("R8 status cleared", d, 32'h0);

    // R9 R10 writes while running, no end flag requested
    put_desc(32'h180, 32'h1, 32'h1000, 32'h4400, mk_cmd(200, 0, 1, 1, 0));
    clr_stats();
    reg_wr(PTR, 32'h180);
    reg_wr(CTL, 32'h1);
    reg_rd(STS, d); chk("R9 running", {31'b0, d[0]}, 1);
    reg_wr(PTR, 32'h3E0);
    reg_rd(PTR, d); chk("R10 ptr locked while running", d, 32'h180);
    reg_wr(CTL, 32'h1);
    wait_idle();
    chk("R9 restart ignored", fetch_n, 4);
    reg_rd(STS, d); chk("R9 stopped", d, 0);
    #1 chk("R8 no flag without request", {31'b0, irq}, 0);

    // R11 maximum length
    for (int i = 0; i < 8191; i++) mem[16'h1000 + i] = 8'((i ^ (i >> 8)) & 255);
    mem[16'h4000 + 8191] = 8'hEE;
    put_desc(32'h100, 32'h1, 32'h1000, 32'h4000, mk_cmd(8191, 2, 1, 1, 0));
    run_chain(32'h100);
    mism = 0;
    for (int i = 0; i < 8191; i++) if (mem[16'h4000 + i] !== mem[16'h1000 + i]) mism++;
    chk("R11 data", mism, 0);
    chk("R11 read count", rd_n, 8191);
    chk("R11 longest run", max_run, 32);
    chk("R11 sentinel", {24'b0, mem[16'h4000 + 8191]}, 32'hEE);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule